// File: doc/BRIEF.md
# Dual-Channel Diagnostic Compare Unit

This block watches two copies of the same control-signal vector, one from a primary source and one from a redundant secondary source. In its normal mode it compares them on every clock and flags a compare error on the cycle after they differ. It also records which bit positions have disagreed. A small register port holds a 4-bit mode key and two write-1-to-clear status registers.

Three diagnostic modes prove that the checker itself works. The self-test mode ignores the live inputs and feeds the comparator an all-ones vector against a copy with one bit inverted. It does this for every bit position, first with the inversion on the secondary side and then on the primary side. Any injected difference that the comparator misses raises a self-test error. The two forcing modes each drive one of the two error outputs for a single cycle, so that software can see that the output is not stuck low. After each diagnostic mode the unit falls back to normal compare by itself.

While the processor is halted for debugging, the unit raises no error, pulses nothing and stalls any mode still in progress. It resumes where it stopped once the halt input drops.

Top module: `dcmp_unit`

## Requirements
- R1: In compare mode (key code 0x5), `cmp_err` is high on the cycle after `pri_vec` and `sec_vec` differ, and low on the cycle after they are equal.
- R2: Each bit on which the two vectors differ in compare mode is ORed into the mismatch register at offset 0x08. Writing 1 to a bit there clears that bit.
- R3: Writing the key register at offset 0x00 with 0x5, 0x6, 0x9 or 0xF selects compare, self-test, error-force or self-test-error-force mode. Any other value selects compare mode. Reading offset 0x00 returns the current mode code in bits [3:0].
- R4: Self-test takes one cycle per injected pattern, 2×VEC_W cycles in all. Throughout the test the live inputs are ignored and `cmp_err` stays low.
- R5: On the last self-test cycle `st_done` pulses high for one cycle and the mode returns to 0x5. On a correct comparator `st_err` stays low. Status bit 2 (offset 0x04) is set.
- R6: Error-force mode drives `cmp_err` high for exactly one cycle through the comparator, then returns to mode 0x5. Status bit 0 is set.
- R7: Self-test-error-force mode drives `st_err` high for exactly one cycle, then returns to mode 0x5. Status bit 1 is set.
- R8: While `dbg_halt` is high, `cmp_err`, `st_err` and `st_done` stay low, the status and mismatch registers gain no bits, and a pending mode stalls until the halt drops.
- R9: The status register at offset 0x04 is write-1-to-clear per bit: bit 0 compare error, bit 1 self-test error, bit 2 self-test done.
- R10: A read or write to any offset other than 0x00, 0x04 or 0x08 makes `reg_err` high on the next cycle, and a read of such an offset returns zero.
- R11: Read data appears on `reg_rdata` on the cycle after `reg_rd` is sampled, and is zero when no read was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_vec | input | VEC_W | Primary copy of the compared vector |
| sec_vec | input | VEC_W | Secondary copy of the compared vector |
| dbg_halt | input | 1 | Processor halted for debug; suppresses errors and status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, one cycle after the read |
| reg_err | output | 1 | Access to an unimplemented offset, one cycle after it |
| cmp_err | output | 1 | Compare error pulse |
| st_err | output | 1 | Self-test error pulse |
| st_done | output | 1 | Self-test completion pulse |

## Verification
The properties assume a key write is never issued on the same cycle as the end of a forced mode whose effect they check. They also assume reads and writes are single-cycle strobes. The stimulus issues one register access at a time and waits for every diagnostic mode to finish before it writes the key again. The one exception is the halt scenario, where the key is written deliberately while `dbg_halt` is high to show that the forced pulse is held back. During self-test the bench drives deliberately unequal live vectors, so a design that lets them through would show a compare error.

// File: rtl/dcmp_pkg.sv
// dcmp_pkg: mode codes, register offsets and the key decoder shared by
// the diagnostic compare unit. Assumes byte offsets fit in 8 bits.
package dcmp_pkg;

    typedef enum logic [3:0] {
        MODE_LOCK     = 4'h5,
        MODE_SELFTEST = 4'h6,
        MODE_FORCE    = 4'h9,
        MODE_STFORCE  = 4'hF
    } dc_mode_e;

    localparam logic [7:0] OFS_KEY  = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_MISS = 8'h08;

    localparam int STAT_CMP  = 0;
    localparam int STAT_STE  = 1;
    localparam int STAT_DONE = 2;
    localparam int STAT_W    = 3;

    // Map a written key onto a mode; unknown codes fall back to compare.
    function automatic dc_mode_e key_to_mode(input logic [3:0] k);
        case (k)
            4'h6:    return MODE_SELFTEST;
            4'h9:    return MODE_FORCE;
            4'hF:    return MODE_STFORCE;
            default: return MODE_LOCK;
        endcase
    endfunction

endpackage

// File: rtl/dcmp_core.sv
// dcmp_core: bitwise comparator. Produces the per-bit difference of two
// operand vectors and a reduced "any difference" flag. Purely combinational;
// assumes the caller registers the result.
module dcmp_core #(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] diff,
    output logic         any_diff
);

    // One XOR per lane so each lane is an independent checker.
    for (genvar i = 0; i < W; i++) begin : g_lane
        assign diff[i] = op_a[i] ^ op_b[i];
    end

    // Reduce the lanes into a single mismatch indication.
    assign any_diff = |diff;

endmodule

// File: rtl/dcmp_seq.sv
// dcmp_seq: mode engine. Selects the comparator operands for the current
// mode, walks the single-bit inversion across both ports in self-test,
// produces the registered error / done pulses and the mismatch log, and
// returns to compare mode after every diagnostic mode. Assumes key_wr is a
// single-cycle strobe; a key write restarts any mode in progress.
module dcmp_seq
    import dcmp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pri_vec,
    input  logic [W-1:0] sec_vec,
    input  logic         halt,
    input  logic         key_wr,
    input  dc_mode_e     key_mode,
    input  logic [W-1:0] diff,
    input  logic         any_diff,
    output logic [W-1:0] op_a,
    output logic [W-1:0] op_b,
    output dc_mode_e     mode,
    output logic         cmp_err,
    output logic         st_err,
    output logic         st_done,
    output logic [W-1:0] log_vec
);

    localparam int BW = (W > 1) ? $clog2(W) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);
    localparam logic [W-1:0]  ONES     = '1;

    logic [BW-1:0] bit_q;
    logic          side_q;
    logic          fail_q;
    logic [W-1:0]  flip;
    logic          last_pat;
    logic          cur_fail;

    // Single inverted lane for the pattern being injected.
    assign flip     = {{(W-1){1'b0}}, 1'b1} << bit_q;
    assign last_pat = side_q && (bit_q == LAST_BIT);
    assign cur_fail = (diff != flip);

    // Operand selection per mode.
    always_comb begin
        op_a = pri_vec;
        op_b = sec_vec;
        case (mode)
            MODE_SELFTEST: begin
                op_a = side_q ? (ONES ^ flip) : ONES;
                op_b = side_q ? ONES : (ONES ^ flip);
            end
            MODE_FORCE: begin
                op_a = ONES;
                op_b = '0;
            end
            MODE_STFORCE: begin
                op_a = ONES;
                op_b = ONES;
            end
            default: ;
        endcase
    end

    // Mode register, self-test walker and registered output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= MODE_LOCK;
            bit_q   <= '0;
            side_q  <= 1'b0;
            fail_q  <= 1'b0;
            cmp_err <= 1'b0;
            st_err  <= 1'b0;
            st_done <= 1'b0;
            log_vec <= '0;
        end else if (key_wr) begin
            mode    <= key_mode;
            bit_q   <= '0;
            side_q  <= 1'b0;
            fail_q  <= 1'b0;
            cmp_err <= 1'b0;
            st_err  <= 1'b0;
            st_done <= 1'b0;
            log_vec <= '0;
        end else if (halt) begin
            cmp_err <= 1'b0;
            st_err  <= 1'b0;
            st_done <= 1'b0;
            log_vec <= '0;
        end else begin
            cmp_err <= 1'b0;
            st_err  <= 1'b0;
            st_done <= 1'b0;
            log_vec <= '0;
            case (mode)
                MODE_SELFTEST: begin
                    if (last_pat) begin
                        st_err  <= fail_q | cur_fail;
                        st_done <= 1'b1;
                        mode    <= MODE_LOCK;
                        bit_q   <= '0;
                        side_q  <= 1'b0;
                        fail_q  <= 1'b0;
                    end else begin
                        fail_q <= fail_q | cur_fail;
                        if (bit_q == LAST_BIT) begin
                            bit_q  <= '0;
                            side_q <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                MODE_FORCE: begin
                    cmp_err <= any_diff;
                    mode    <= MODE_LOCK;
                end
                MODE_STFORCE: begin
                    st_err <= 1'b1;
                    mode   <= MODE_LOCK;
                end
                default: begin
                    cmp_err <= any_diff;
                    log_vec <= diff;
                end
            endcase
        end
    end

endmodule

// File: rtl/dcmp_regs.sv
// dcmp_regs: register port. Decodes the key, status and mismatch offsets,
// returns read data one cycle after a read, flags unimplemented offsets,
// and keeps the write-1-to-clear status bits, where a new event wins over a
// clear in the same cycle. Assumes single-cycle read and write strobes.
module dcmp_regs
    import dcmp_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_err,
    output logic              key_wr,
    output dc_mode_e          key_mode,
    input  dc_mode_e          mode,
    input  logic              cmp_err,
    input  logic              st_err,
    input  logic              st_done,
    input  logic [W-1:0]      log_vec
);

    logic              hit_key, hit_stat, hit_miss, hit_any;
    logic [STAT_W-1:0] stat_q, stat_set, stat_clr;
    logic [W-1:0]      miss_q, miss_clr;

    // Offset decode.
    assign hit_key  = (reg_addr == ADDR_W'(OFS_KEY));
    assign hit_stat = (reg_addr == ADDR_W'(OFS_STAT));
    assign hit_miss = (reg_addr == ADDR_W'(OFS_MISS));
    assign hit_any  = hit_key | hit_stat | hit_miss;

    // Key write strobe and decoded mode toward the engine.
    assign key_wr   = reg_wr & hit_key;
    assign key_mode = key_to_mode(reg_wdata[3:0]);

    // Set and clear vectors for the sticky registers.
    always_comb begin
        stat_set            = '0;
        stat_set[STAT_CMP]  = cmp_err;
        stat_set[STAT_STE]  = st_err;
        stat_set[STAT_DONE] = st_done;
        stat_clr            = (reg_wr & hit_stat) ? reg_wdata[STAT_W-1:0] : '0;
        miss_clr            = (reg_wr & hit_miss) ? reg_wdata[W-1:0] : '0;
    end

    // Sticky status and mismatch registers plus the registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q    <= '0;
            miss_q    <= '0;
            reg_rdata <= '0;
            reg_err   <= 1'b0;
        end else begin
            stat_q    <= (stat_q & ~stat_clr) | stat_set;
            miss_q    <= (miss_q & ~miss_clr) | log_vec;
            reg_rdata <= '0;
            reg_err   <= (reg_wr | reg_rd) & ~hit_any;
            if (reg_rd) begin
                if (hit_key)
                    reg_rdata <= DATA_W'(mode);
                else if (hit_stat)
                    reg_rdata <= DATA_W'(stat_q);
                else if (hit_miss)
                    reg_rdata <= DATA_W'(miss_q);
            end
        end
    end

endmodule

// File: rtl/dcmp_unit.sv
// dcmp_unit: top of the dual-channel diagnostic compare unit. Wires the
// register port, the mode engine and the comparator together. Assumes
// VEC_W does not exceed DATA_W and that the two vectors are synchronous
// to clk.
module dcmp_unit
    import dcmp_pkg::*;
#(
    parameter int VEC_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VEC_W-1:0]  pri_vec,
    input  logic [VEC_W-1:0]  sec_vec,
    input  logic              dbg_halt,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_err,
    output logic              cmp_err,
    output logic              st_err,
    output logic              st_done
);

    logic [VEC_W-1:0] op_a, op_b, diff, log_vec;
    logic             any_diff;
    logic             key_wr_w;
    dc_mode_e         key_mode_w;
    dc_mode_e         mode_w;

    // Register port.
    dcmp_regs #(.W(VEC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_err   (reg_err),
        .key_wr    (key_wr_w),
        .key_mode  (key_mode_w),
        .mode      (mode_w),
        .cmp_err   (cmp_err),
        .st_err    (st_err),
        .st_done   (st_done),
        .log_vec   (log_vec)
    );

    // Mode engine and self-test walker.
    dcmp_seq #(.W(VEC_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pri_vec  (pri_vec),
        .sec_vec  (sec_vec),
        .halt     (dbg_halt),
        .key_wr   (key_wr_w),
        .key_mode (key_mode_w),
        .diff     (diff),
        .any_diff (any_diff),
        .op_a     (op_a),
        .op_b     (op_b),
        .mode     (mode_w),
        .cmp_err  (cmp_err),
        .st_err   (st_err),
        .st_done  (st_done),
        .log_vec  (log_vec)
    );

    // Shared comparator, used by every mode.
    dcmp_core #(.W(VEC_W)) u_core (
        .op_a     (op_a),
        .op_b     (op_b),
        .diff     (diff),
        .any_diff (any_diff)
    );

endmodule

// File: rtl/dcmp_chk.sv
// dcmp_chk: temporal properties of dcmp_unit, attached with bind. Assumes
// key writes are single-cycle strobes.
module dcmp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dbg_halt,
    input logic [3:0] mode,
    input logic       key_wr,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic       reg_err,
    input logic       cmp_err,
    input logic       st_err,
    input logic       st_done
);

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_halt |=> (!cmp_err && !st_err && !st_done));

    // R6
    force_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'h9 && !dbg_halt && !key_wr) |=> (cmp_err && mode == 4'h5));

    // R7
    stforce_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'hF && !dbg_halt && !key_wr) |=> (st_err && mode == 4'h5));

    // R5
    done_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |-> (mode == 4'h5));

    // R4
    cmp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_err |-> $past(mode == 4'h5 || mode == 4'h9));

    // R7
    ste_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_err |-> $past(mode == 4'h6 || mode == 4'hF));

    // R10
    bus_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> $past(reg_wr || reg_rd));

endmodule

bind dcmp_unit dcmp_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dbg_halt (dbg_halt),
    .mode     (mode_w),
    .key_wr   (key_wr_w),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_err  (reg_err),
    .cmp_err  (cmp_err),
    .st_err   (st_err),
    .st_done  (st_done)
);

// File: tb/sim_dcmp_unit.sv
module sim_dcmp_unit;

    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pri_vec = '0;
    logic [N-1:0]  sec_vec = '0;
    logic          dbg_halt = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          reg_err, cmp_err, st_err, st_done;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [31:0] act;

    typedef struct {
        int          cyc;
        int          sel;   // 0 cmp_err 1 st_err 2 st_done 3 rdata 4 reg_err
        logic [31:0] val;
        string       req;
    } exp_t;
    exp_t sb[$];

    dcmp_unit #(.VEC_W(N)) u0 (
        .clk(clk), .rst_n(rst_n), .pri_vec(pri_vec), .sec_vec(sec_vec),
        .dbg_halt(dbg_halt), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_err(reg_err), .cmp_err(cmp_err), .st_err(st_err), .st_done(st_done)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop every expectation due this cycle and compare.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cyc) begin
                case (sb[i].sel)
                    0: act = {31'b0, cmp_err};
                    1: act = {31'b0, st_err};
                    2: act = {31'b0, st_done};
                    3: act = reg_rdata;
                    default: act = {31'b0, reg_err};
                endcase
                n_chk++;
                if (act !== sb[i].val) begin
                    n_fail++;
                    $display("FAIL %s sel=%0d cyc=%0d got %h expected %h",
                             sb[i].req, sb[i].sel, cyc, act, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    task automatic push(input int c, input int sel, input logic [31:0] v, input string req);
        exp_t e;
        e.cyc = c; e.sel = sel; e.val = v; e.req = req;
        sb.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit mapped(input logic [7:0] a);
        return (a == 8'h00) || (a == 8'h04) || (a == 8'h08);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        push(cyc + 1, 4, {31'b0, !mapped(a)}, req);
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
        reg_rd = 1'b1; reg_addr = a;
        push(cyc + 1, 3, mapped(a) ? e : 32'h0, req);
        push(cyc + 1, 4, {31'b0, !mapped(a)}, req);
        tick(1);
        reg_rd = 1'b0;
    endtask

    task automatic vec(input logic [N-1:0] p, input logic [N-1:0] s, input string req);
        pri_vec = p; sec_vec = s;
        push(cyc + 1, 0, {31'b0, p != s}, req);
        tick(1);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Driver.
    initial begin
        tick(2);
        push(cyc + 1, 0, 0, "reset"); push(cyc + 1, 1, 0, "reset");
        push(cyc + 1, 2, 0, "reset"); push(cyc + 1, 4, 0, "reset");
        tick(2);
        rst_n = 1'b1;
        rd(8'h00, 32'h5, "R3 reset mode");
        rd(8'h04, 32'h0, "R9 reset status");

        // R1 compare patterns
        vec(32'hA5A5_5A5A, 32'hA5A5_5A5A, "R1 equal");
        vec(32'h0000_0001, 32'h0000_0000, "R1 lsb");
        vec(32'h8000_0000, 32'h0000_0000, "R1 msb");
        vec(32'h1234_5678, 32'h1234_5678, "R1 equal again");
        rd(8'h08, 32'h8000_0001, "R2 mismatch log");
        rd(8'h04, 32'h1, "R9 compare bit");
        wr(8'h08, 32'h0000_0001, "R2 clear");
        rd(8'h08, 32'h8000_0000, "R2 after clear");
        wr(8'h04, 32'h1, "R9 clear");
        rd(8'h04, 32'h0, "R9 after clear");

        // R3 illegal keys
        wr(8'h00, 32'h3, "R3 key 3");
        rd(8'h00, 32'h5, "R3 fallback");
        wr(8'h00, 32'h0, "R3 key 0");
        rd(8'h00, 32'h5, "R3 fallback 0");

        // R6 error force
        wr(8'h00, 32'h9, "R6 key");
        push(cyc + 1, 0, 1, "R6 pulse"); push(cyc + 2, 0, 0, "R6 one cycle");
        tick(3);
        rd(8'h00, 32'h5, "R6 mode back");
        rd(8'h04, 32'h1, "R6 status");

        // R7 self-test error force
        wr(8'h00, 32'hF, "R7 key");
        push(cyc + 1, 1, 1, "R7 pulse"); push(cyc + 2, 1, 0, "R7 one cycle");
        tick(3);
        rd(8'h00, 32'h5, "R7 mode back");
        rd(8'h04, 32'h3, "R7 status");
        wr(8'h04, 32'h2, "R9 partial clear");
        rd(8'h04, 32'h1, "R9 partial");
        wr(8'h04, 32'h7, "R9 clear all");
        wr(8'h08, 32'hFFFF_FFFF, "R2 clear all");

        // R4 / R5 self-test with unequal live inputs
        wr(8'h00, 32'h6, "R4 key");
        pri_vec = 32'hFFFF_FFFF; sec_vec = 32'h0;
        for (int k = 1; k <= 2 * N; k++) begin
            push(cyc + k, 0, 0, "R4 inputs ignored");
            push(cyc + k, 1, 0, "R5 no self-test error");
            push(cyc + k, 2, (k == 2 * N) ? 1 : 0, "R5 done timing");
        end
        push(cyc + 2 * N + 1, 0, 1, "R1 compare resumes");
        push(cyc + 2 * N + 1, 2, 0, "R5 done one cycle");
        tick(2 * N + 1);
        pri_vec = '0;
        push(cyc + 1, 0, 0, "R1 equal after test");
        tick(1);
        rd(8'h00, 32'h5, "R5 mode back");
        rd(8'h04, 32'h5, "R5 status done");
        rd(8'h08, 32'hFFFF_FFFF, "R2 only live mismatch logged");
        wr(8'h04, 32'h7, "R9 clear");
        wr(8'h08, 32'hFFFF_FFFF, "R2 clear");

        // R8 debug halt
        dbg_halt = 1'b1;
        pri_vec = 32'h0000_00F0; sec_vec = 32'h0;
        push(cyc + 1, 0, 0, "R8 halted");
        tick(1);
        wr(8'h00, 32'h9, "R8 key while halted");
        for (int k = 1; k <= 4; k++) push(cyc + k, 0, 0, "R8 force stalled");
        tick(4);
        rd(8'h04, 32'h0, "R8 no status");
        rd(8'h08, 32'h0, "R8 no log");
        rd(8'h00, 32'h9, "R8 mode pending");
        pri_vec = '0;
        dbg_halt = 1'b0;
        push(cyc + 1, 0, 1, "R8 resumes force");
        push(cyc + 2, 0, 0, "R8 back to compare");
        tick(3);

        // R10 / R11 unimplemented offsets
        rd(8'h0C, 32'h0, "R10 read hole");
        wr(8'h40, 32'h1, "R10 write hole");
        push(cyc + 1, 3, 0, "R11 idle rdata");
        push(cyc + 1, 4, 0, "R10 idle");
        tick(4);

        if (sb.size() != 0) begin
            n_fail += sb.size();
            $display("FAIL scoreboard left %0d items", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule